// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a word-addressed backing memory. It keeps a small number of one-word lines, four by default, each holding a single 16-bit word with its own tag, valid flag and dirty flag. The line for a word address is chosen by the low address bits (the address modulo the line count). The remaining high bits (the address divided by the line count) form the tag. A load or store whose word is already resident is a hit and is answered from the local store without touching memory.

On a miss, the displaced line is first written back to memory, but only if it is both valid and dirty. The requested word is then fetched. Stores also allocate a line when they miss: the fetched word is replaced by the store data and the line is left dirty. Loads that refill a line leave it clean. The processor side accepts one request at a time and answers with a one-cycle response pulse carrying the read data and a hit flag. Two saturating counters tally hits and misses.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset every line is invalid, both counters read zero, `cpu_req_ready` is high and no memory request is pending. The first access to any line is therefore a miss.
- R2: A word address selects line `addr mod LINES` and tag `addr div LINES`. Addresses that are equal modulo LINES compete for one line (with 4 lines, addresses 1, 5, 9 and 13 share line 1).
- R3: A hit is answered by `cpu_rsp_valid` with `cpu_rsp_hit`=1 in the cycle after the request is accepted, with no memory request.
- R4: A load returns the value most recently stored to that address, whether the word is resident or has to be fetched back from memory.
- R5: A store miss allocates the line (write-allocate), so a following load of the same address is a hit that returns the stored value.
- R6: A miss on a line that is valid and dirty writes the old word to its own address (old tag joined with the line index) before the read of the new address is issued, and only one handshake cycle separates the two.
- R7: A miss on an invalid line or a clean line issues exactly one memory read and no write.
- R8: A line refilled by a load stays clean, so evicting it later produces no writeback. A line written by a store hit stays dirty.
- R9: The hit counter and the miss counter each rise by one per hit or miss, and never by more. Neither moves in the same cycle as the other, and each stops at 2^CNT_W-1.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request and its address, direction and data remain unchanged.
- R11: `cpu_req_ready` is low from acceptance until the response pulse has been given. At most one of `cpu_req_ready`, `cpu_rsp_valid` and `mem_req_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | DATA_W | Load result (store data for stores) |
| cpu_rsp_hit | output | 1 | Response was a hit |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 = writeback, 0 = refill read |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Writeback data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | DATA_W | Read data |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
A wrong tag or valid bit shows as a wrong `cpu_rsp_hit` flag in the response to the very access that consults that line. It also shows as a memory read that should not appear, or one that is missing, during that access. A wrong dirty bit stays hidden until that line is next evicted, when a writeback is missing or extra. A wrong data word is caught at the next load of that address or at the writeback, where the bench compares the written-back value against its own model. The bench replays a fixed conflict sequence, an address sweep and a long pseudo-random run against an arithmetic model of the mapping, so each such fault surfaces within a handful of accesses.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITEBACK,
    ST_REFILL,
    ST_REFILL_WAIT,
    ST_RESPOND
  } ctrl_state_t;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int LINES = 4,
  parameter int TAG_W = 2,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty
);

  logic             valid_q [LINES];
  logic             dirty_q [LINES];
  logic [TAG_W-1:0] tag_q   [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
      end
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/cache_data_ram.sv
module cache_data_ram #(
  parameter int LINES  = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] store_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_idx] <= wr_data;
  end

  assign rd_data = store_q[rd_idx];

endmodule

// File: rtl/cache_sat_counter.sv
module cache_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              cpu_rsp_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic [IDX_W-1:0]  look_idx,
  input  logic              look_valid,
  input  logic              look_dirty,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic [DATA_W-1:0] look_data,
  output logic              tag_wr_en,
  output logic [IDX_W-1:0]  tag_wr_idx,
  output logic [TAG_W-1:0]  tag_wr_tag,
  output logic              tag_wr_dirty,
  output logic              dat_wr_en,
  output logic [IDX_W-1:0]  dat_wr_idx,
  output logic [DATA_W-1:0] dat_wr_data,
  output logic              hit_inc,
  output logic              miss_inc
);

  ctrl_state_t       state_q;
  logic              we_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              hit_q;

  logic [IDX_W-1:0]  in_idx;
  logic [TAG_W-1:0]  in_tag;
  logic              accept;
  logic              look_hit;
  logic [DATA_W-1:0] fill_word;

  assign in_idx    = cpu_req_addr[IDX_W-1:0];
  assign in_tag    = cpu_req_addr[ADDR_W-1:IDX_W];
  assign accept    = (state_q == ST_IDLE) && cpu_req_valid;
  assign look_idx  = (state_q == ST_IDLE) ? in_idx : idx_q;
  assign look_hit  = look_valid && (look_tag == in_tag);
  assign fill_word = we_q ? wdata_q : mem_rsp_rdata;

  always_comb begin
    tag_wr_en    = 1'b0;
    tag_wr_idx   = in_idx;
    tag_wr_tag   = in_tag;
    tag_wr_dirty = 1'b1;
    dat_wr_en    = 1'b0;
    dat_wr_idx   = in_idx;
    dat_wr_data  = cpu_req_wdata;
    hit_inc      = 1'b0;
    miss_inc     = 1'b0;
    if (accept) begin
      if (look_hit) begin
        hit_inc = 1'b1;
        if (cpu_req_we) begin
          tag_wr_en = 1'b1;
          dat_wr_en = 1'b1;
        end
      end else begin
        miss_inc = 1'b1;
      end
    end else if (state_q == ST_REFILL_WAIT && mem_rsp_valid) begin
      tag_wr_en    = 1'b1;
      tag_wr_idx   = idx_q;
      tag_wr_tag   = tag_q;
      tag_wr_dirty = we_q;
      dat_wr_en    = 1'b1;
      dat_wr_idx   = idx_q;
      dat_wr_data  = fill_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      idx_q   <= '0;
      tag_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            we_q    <= cpu_req_we;
            idx_q   <= in_idx;
            tag_q   <= in_tag;
            wdata_q <= cpu_req_wdata;
            hit_q   <= look_hit;
            if (look_hit) begin
              rdata_q <= cpu_req_we ? cpu_req_wdata : look_data;
              state_q <= ST_RESPOND;
            end else if (look_valid && look_dirty) begin
              state_q <= ST_WRITEBACK;
            end else begin
              state_q <= ST_REFILL;
            end
          end
        end
        ST_WRITEBACK: if (mem_req_ready) state_q <= ST_REFILL;
        ST_REFILL:    if (mem_req_ready) state_q <= ST_REFILL_WAIT;
        ST_REFILL_WAIT: begin
          if (mem_rsp_valid) begin
            rdata_q <= fill_word;
            state_q <= ST_RESPOND;
          end
        end
        ST_RESPOND: state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign cpu_rsp_valid = (state_q == ST_RESPOND);
  assign cpu_rsp_rdata = rdata_q;
  assign cpu_rsp_hit   = hit_q;
  assign mem_req_valid = (state_q == ST_WRITEBACK) || (state_q == ST_REFILL);
  assign mem_req_we    = (state_q == ST_WRITEBACK);
  assign mem_req_addr  = (state_q == ST_WRITEBACK) ? {look_tag, idx_q} : {tag_q, idx_q};
  assign mem_req_wdata = look_data;

endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  parameter int CNT_W  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_req_ready,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              cpu_rsp_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  logic [IDX_W-1:0]  look_idx;
  logic              look_valid;
  logic              look_dirty;
  logic [TAG_W-1:0]  look_tag;
  logic [DATA_W-1:0] look_data;
  logic              tag_wr_en;
  logic [IDX_W-1:0]  tag_wr_idx;
  logic [TAG_W-1:0]  tag_wr_tag;
  logic              tag_wr_dirty;
  logic              dat_wr_en;
  logic [IDX_W-1:0]  dat_wr_idx;
  logic [DATA_W-1:0] dat_wr_data;
  logic              hit_inc;
  logic              miss_inc;
  logic [1:0]        cnt_inc;
  logic [CNT_W-1:0]  cnt_val [2];

  cache_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .rd_idx(look_idx), .rd_valid(look_valid), .rd_dirty(look_dirty), .rd_tag(look_tag),
    .wr_en(tag_wr_en), .wr_idx(tag_wr_idx), .wr_tag(tag_wr_tag), .wr_dirty(tag_wr_dirty)
  );

  cache_data_ram #(.LINES(LINES), .DATA_W(DATA_W)) u_data (
    .clk(clk),
    .wr_en(dat_wr_en), .wr_idx(dat_wr_idx), .wr_data(dat_wr_data),
    .rd_idx(look_idx), .rd_data(look_data)
  );

  cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_we(cpu_req_we),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata), .cpu_rsp_hit(cpu_rsp_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .look_idx(look_idx), .look_valid(look_valid), .look_dirty(look_dirty),
    .look_tag(look_tag), .look_data(look_data),
    .tag_wr_en(tag_wr_en), .tag_wr_idx(tag_wr_idx), .tag_wr_tag(tag_wr_tag),
    .tag_wr_dirty(tag_wr_dirty),
    .dat_wr_en(dat_wr_en), .dat_wr_idx(dat_wr_idx), .dat_wr_data(dat_wr_data),
    .hit_inc(hit_inc), .miss_inc(miss_inc)
  );

  assign cnt_inc = {miss_inc, hit_inc};

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    cache_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(cnt_inc[k]), .count(cnt_val[k])
    );
  end

  assign hit_count  = cnt_val[0];
  assign miss_count = cnt_val[1];

endmodule

// File: rtl/cache_checker.sv
module cache_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              cpu_rsp_hit,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (hit_count == '0 && miss_count == '0 && cpu_req_ready && !mem_req_valid));

  a_r3_hit_no_memory: assert property (@(posedge clk) disable iff (rst)
    (cpu_rsp_valid && cpu_rsp_hit) |-> !$past(mem_req_valid));

  a_r6_wb_then_read: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_we && mem_req_ready) |=> (mem_req_valid && !mem_req_we));

  a_r9_hit_step: assert property (@(posedge clk) disable iff (rst)
    (hit_count == $past(hit_count)) || (hit_count == $past(hit_count) + 1'b1));

  a_r9_miss_step: assert property (@(posedge clk) disable iff (rst)
    (miss_count == $past(miss_count)) || (miss_count == $past(miss_count) + 1'b1));

  a_r9_not_both: assert property (@(posedge clk) disable iff (rst)
    !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))));

  a_r10_req_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr) && $stable(mem_req_wdata)));

  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_req_ready, cpu_rsp_valid, mem_req_valid}));

endmodule

bind dm_wb_cache cache_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_checker (
  .clk(clk), .rst(rst),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_hit(cpu_rsp_hit),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/tb_dm_wb_cache.sv
module tb_dm_wb_cache;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NL = 4;
  localparam int CW = 8;
  localparam int NWORDS = 1 << AW;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req_valid = 1'b0;
  logic          cpu_req_we = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic          cpu_req_ready;
  logic          cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          cpu_rsp_hit;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic          mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_rdata = '0;
  logic [CW-1:0] hit_count;
  logic [CW-1:0] miss_count;

  dm_wb_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .CNT_W(CW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // backing memory model with uneven ready
  logic [DW-1:0] bmem [NWORDS];
  logic [1:0]    rdy_phase = '0;
  int            wb_cnt = 0;
  int            rd_cnt = 0;
  int            rd_at_wb = 0;
  int            last_wb_addr = 0;
  int            last_wb_data = 0;
  int            last_rd_addr = 0;

  initial for (int i = 0; i < NWORDS; i++) bmem[i] = '0;

  always @(posedge clk) begin
    rdy_phase     <= rdy_phase + 1'b1;
    mem_req_ready <= (rdy_phase != 2'd1);
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        bmem[mem_req_addr] <= mem_req_wdata;
        wb_cnt       <= wb_cnt + 1;
        rd_at_wb     <= rd_cnt;
        last_wb_addr <= int'(mem_req_addr);
        last_wb_data <= int'(mem_req_wdata);
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= bmem[mem_req_addr];
        rd_cnt        <= rd_cnt + 1;
        last_rd_addr  <= int'(mem_req_addr);
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      bad = bad + 1;
      total = total + 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // reference model of the mapping
  bit            rv [NL];
  bit            rdty [NL];
  int            rt [NL];
  logic [DW-1:0] rmem [NWORDS];
  int            exp_hits = 0;
  int            exp_miss = 0;
  logic [15:0]   lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic access(input bit we, input int addr, input logic [DW-1:0] wd);
    int  idx = addr % NL;
    int  tg  = addr / NL;
    bit  e_hit = rv[idx] && (rt[idx] == tg);
    bit  e_wb  = !e_hit && rv[idx] && rdty[idx];
    int  e_wb_addr = rt[idx] * NL + idx;
    int  e_wb_data = int'(rmem[e_wb_addr]);
    int  wb0, rd0;
    while (!cpu_req_ready) @(negedge clk);
    wb0 = wb_cnt;
    rd0 = rd_cnt;
    cpu_req_valid = 1'b1;
    cpu_req_we    = we;
    cpu_req_addr  = AW'(addr);
    cpu_req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (e_hit) chk(cpu_rsp_valid, "R3 hit response latency", int'(cpu_rsp_valid), 1);
    while (!cpu_rsp_valid) @(negedge clk);
    // model update
    if (e_hit) exp_hits = (exp_hits < CMAX) ? exp_hits + 1 : CMAX;
    else       exp_miss = (exp_miss < CMAX) ? exp_miss + 1 : CMAX;
    if (we) rmem[addr] = wd;
    rdty[idx] = e_hit ? (rdty[idx] | we) : we;
    rv[idx] = 1'b1;
    rt[idx] = tg;
    chk(cpu_rsp_hit == e_hit, "R2 hit flag", int'(cpu_rsp_hit), int'(e_hit));
    if (!we) chk(cpu_rsp_rdata == rmem[addr], "R4 load data", int'(cpu_rsp_rdata), int'(rmem[addr]));
    chk((rd_cnt - rd0) == (e_hit ? 0 : 1), "R7 refill reads", rd_cnt - rd0, e_hit ? 0 : 1);
    if (!e_hit) chk(last_rd_addr == addr, "R2 refill address", last_rd_addr, addr);
    chk((wb_cnt - wb0) == (e_wb ? 1 : 0), "R8 writeback count", wb_cnt - wb0, e_wb ? 1 : 0);
    if (e_wb) begin
      chk(last_wb_addr == e_wb_addr, "R6 writeback address", last_wb_addr, e_wb_addr);
      chk(last_wb_data == e_wb_data, "R6 writeback data", last_wb_data, e_wb_data);
      chk(rd_at_wb == rd0, "R6 writeback precedes read", rd_at_wb, rd0);
    end
    chk(int'(hit_count) == exp_hits, "R9 hit counter", int'(hit_count), exp_hits);
    chk(int'(miss_count) == exp_miss, "R9 miss counter", int'(miss_count), exp_miss);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin rv[i] = 0; rdty[i] = 0; rt[i] = 0; end
    for (int i = 0; i < NWORDS; i++) rmem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cpu_req_ready == 1'b1, "R1 ready after reset", int'(cpu_req_ready), 1);
    chk(hit_count == '0, "R1 hit counter reset", int'(hit_count), 0);
    chk(miss_count == '0, "R1 miss counter reset", int'(miss_count), 0);
    chk(!mem_req_valid && !cpu_rsp_valid, "R1 idle outputs", int'(mem_req_valid), 0);

    // conflict sequence on four lines
    access(1, 0, 16'd1);
    access(1, 1, 16'd2);
    access(0, 1, 16'd0);   // R5 store-allocated line hits
    access(1, 2, 16'd3);
    access(1, 3, 16'd4);
    access(0, 1, 16'd0);
    access(1, 7, 16'd5);
    access(1, 8, 16'd6);
    access(1, 9, 16'd7);
    access(0, 1, 16'd0);
    chk(hit_count == 8'd2, "R5 sequence hits", int'(hit_count), 2);
    chk(miss_count == 8'd8, "R2 sequence misses", int'(miss_count), 8);
    chk(bmem[9] == 16'd7, "R6 evicted word in memory", int'(bmem[9]), 7);

    // sweep: store then load every address, then reload all
    for (int a = 0; a < NWORDS; a++) begin
      access(1, a, DW'(a * 7 + 100));
      access(0, a, '0);
    end
    for (int a = 0; a < NWORDS; a++) access(0, a, '0);
    for (int a = 0; a < NWORDS; a++) access(0, NWORDS - 1 - a, '0);

    // pseudo-random traffic
    for (int n = 0; n < 400; n++) begin
      lfsr = step(lfsr);
      access(lfsr[0], int'(lfsr[7:4]), step(lfsr ^ 16'h5A5A));
    end

    // counter saturation
    for (int n = 0; n < 300; n++) access(0, 5, '0);
    chk(hit_count == 8'hFF, "R9 hit saturation", int'(hit_count), 255);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule